// File: doc/BRIEF.md
# SCI Event Source to GPE Router

This block gathers a bank of raw hardware event inputs and folds them onto a smaller set of general-purpose event (GPE) lines. Each source passes through a two-flop synchronizer. A programmable map entry for each source then names the GPE it feeds. A GPE's input is the OR of every synchronized source currently mapped to it.

Each GPE has its own polarity and its own edge-or-level setting. When a GPE detects an event, it sets its status bit. A status bit that is also enabled raises the single system control interrupt output. Software programs the map with byte writes and the polarity, trigger-mode and enable words with 32-bit writes. It clears status by writing ones. Register reads return data in the same cycle and do not change any state.

Top module: `sci_gpe_router`

## Requirements
- R1: After reset, every map entry reads 0 and the polarity, trigger-mode, enable and status words read 0. The interrupt output is low. No status bit sets in the cycles after reset while all sources stay low.
- R2: A byte write (bus_size = 0) to address 0x40 + X stores the low 5 bits of bus_wdata as the GPE number for source X. A read of that address returns the entry zero-extended, so a written 0xFF reads back as 0x1F.
- R3: A word write (bus_size = 1) to 0x08 (polarity, 1 = active high), 0x0C (trigger mode, 1 = level) or 0x14 (enable) stores all 32 bits, bit g belonging to GPE g. The other words keep their values.
- R4: A GPE's input is the OR of all sources mapped to it. When a second source mapped to a GPE that is already active rises, the edge-mode status of that GPE does not set.
- R5: In edge mode with active-high polarity, a rising source sets the status bit of its GPE. The bit stays set after the source falls, until software clears it.
- R6: With active-low polarity, the status bit sets on the source's falling transition, and not on its rising one.
- R7: In level mode, the status bit is set again on every cycle its GPE stays active. A clear that coincides with a set leaves the bit at 1.
- R8: A word write to 0x10 clears exactly the status bits written as 1, and leaves the others unchanged.
- R9: sci_out is high exactly when some status bit and its enable bit are both 1. It follows a change of the enable word in the cycle after the write.
- R10: A source change made between two rising edges shows in status after the third rising edge that follows it, and not before. Status bits never rise without a detected event.
- R11: Accesses of the wrong size have no effect: a byte write to 0x08 leaves the polarity word unchanged, and a word write to a map address leaves that map entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_in | input | 58 | Raw asynchronous event sources |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_size | input | 1 | Access size: 0 byte, 1 word |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sci_out | output | 1 | Interrupt request, OR of enabled status bits |

## Verification
A source change is due in status and in sci_out after the third rising edge: two edges go to the synchronizer and one to the status flop. A register write is due after the single edge on which bus_wr is high, and read data is due in the same cycle as the address. The bench drives inputs on the falling edge and reads one nanosecond after a falling edge. It therefore samples the cycle after one, two and three rising edges to pin the latency, and checks held states over several cycles. In the random phase, a cycle model in the bench advances on each rising edge from the same inputs. The bench compares status and sci_out with the model once per cycle.

// File: rtl/sgr_pkg.sv
`timescale 1ns/1ps
// Shared constants for the SCI/GPE router: bus geometry, register
// addresses and the access-size encoding.
package sgr_pkg;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] POL_OFS  = 8'h08;
    localparam logic [BUS_AW-1:0] TRIG_OFS = 8'h0C;
    localparam logic [BUS_AW-1:0] STAT_OFS = 8'h10;
    localparam logic [BUS_AW-1:0] ENA_OFS  = 8'h14;
    localparam logic [BUS_AW-1:0] MAP_OFS  = 8'h40;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_e;
endpackage

// File: rtl/sgr_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a slow level, so per-bit skew between lanes is harmless.
module sgr_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Shift the raw inputs through two flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sgr_regs.sv
`timescale 1ns/1ps
// Register file: per-source map bytes, polarity, trigger-mode and enable
// words, the write-one-to-clear strobe for status, and the read mux.
// Assumes one access per cycle; reads are side-effect free.
module sgr_regs import sgr_pkg::*; #(
    parameter int NUM_SRC = 58,
    parameter int NUM_GPE = 32,
    parameter int GPE_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_size,
    input  logic [BUS_AW-1:0]        bus_addr,
    input  logic [BUS_DW-1:0]        bus_wdata,
    input  logic [NUM_GPE-1:0]       status_q,
    output logic [NUM_SRC*GPE_W-1:0] map_flat,
    output logic [NUM_GPE-1:0]       pol_q,
    output logic [NUM_GPE-1:0]       trig_q,
    output logic [NUM_GPE-1:0]       ena_q,
    output logic [NUM_GPE-1:0]       clr_mask,
    output logic [BUS_DW-1:0]        bus_rdata
);
    logic [GPE_W-1:0] map_q [NUM_SRC];
    logic             byte_wr;
    logic             word_wr;

    assign byte_wr = bus_wr && (bus_size == ACC_BYTE);
    assign word_wr = bus_wr && (bus_size == ACC_WORD);

    // Map bytes: a byte write to an entry keeps the low GPE_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SRC; s++) map_q[s] <= '0;
        end else if (byte_wr) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (bus_addr == MAP_OFS + BUS_AW'(s)) map_q[s] <= bus_wdata[GPE_W-1:0];
            end
        end
    end

    // Per-GPE control words, written whole by word accesses only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            trig_q <= '0;
            ena_q  <= '0;
        end else if (word_wr) begin
            if (bus_addr == POL_OFS)  pol_q  <= bus_wdata[NUM_GPE-1:0];
            if (bus_addr == TRIG_OFS) trig_q <= bus_wdata[NUM_GPE-1:0];
            if (bus_addr == ENA_OFS)  ena_q  <= bus_wdata[NUM_GPE-1:0];
        end
    end

    // Pack the map for the routing stage.
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) map_flat[s*GPE_W +: GPE_W] = map_q[s];
    end

    // Status clear strobe from a word write of ones.
    always_comb begin
        clr_mask = '0;
        if (word_wr && bus_addr == STAT_OFS) clr_mask = bus_wdata[NUM_GPE-1:0];
    end

    // Read mux, zero-extending every field.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            POL_OFS:  bus_rdata[NUM_GPE-1:0] = pol_q;
            TRIG_OFS: bus_rdata[NUM_GPE-1:0] = trig_q;
            STAT_OFS: bus_rdata[NUM_GPE-1:0] = status_q;
            ENA_OFS:  bus_rdata[NUM_GPE-1:0] = ena_q;
            default: begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (bus_addr == MAP_OFS + BUS_AW'(s)) bus_rdata[GPE_W-1:0] = map_q[s];
                end
            end
        endcase
    end
endmodule

// File: rtl/sgr_route.sv
`timescale 1ns/1ps
// Many-to-one routing: each GPE input is the OR of all synchronized
// sources whose map entry names that GPE. Purely combinational.
module sgr_route #(
    parameter int NUM_SRC = 58,
    parameter int NUM_GPE = 32,
    parameter int GPE_W   = 5
) (
    input  logic [NUM_SRC-1:0]       src_sync,
    input  logic [NUM_SRC*GPE_W-1:0] map_flat,
    output logic [NUM_GPE-1:0]       gpe_raw
);
    for (genvar g = 0; g < NUM_GPE; g++) begin : g_gpe
        logic hit;

        // OR together the sources steered to this GPE.
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (src_sync[s] && map_flat[s*GPE_W +: GPE_W] == GPE_W'(g)) hit = 1'b1;
            end
        end

        assign gpe_raw[g] = hit;
    end
endmodule

// File: rtl/sgr_detect.sv
`timescale 1ns/1ps
// Per-GPE event detection and status. The polarity maps the raw line to
// "active". Edge mode fires on entry into active, and level mode fires on
// every active cycle. A set beats a coinciding clear. The previous-active
// flops reset to 1, so a line that is already active is not an edge.
module sgr_detect #(
    parameter int NUM_GPE = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GPE-1:0] gpe_raw,
    input  logic [NUM_GPE-1:0] pol_q,
    input  logic [NUM_GPE-1:0] trig_q,
    input  logic [NUM_GPE-1:0] clr_mask,
    output logic [NUM_GPE-1:0] set_vec,
    output logic [NUM_GPE-1:0] status_q
);
    logic [NUM_GPE-1:0] act_vec;
    logic [NUM_GPE-1:0] act_q;

    assign act_vec = ~(gpe_raw ^ pol_q);

    for (genvar g = 0; g < NUM_GPE; g++) begin : g_det
        assign set_vec[g] = trig_q[g] ? act_vec[g] : (act_vec[g] & ~act_q[g]);
    end

    // Track activity and accumulate status with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= '1;
            status_q <= '0;
        end else begin
            act_q    <= act_vec;
            status_q <= (status_q & ~clr_mask) | set_vec;
        end
    end
endmodule

// File: rtl/sci_gpe_router.sv
`timescale 1ns/1ps
// Top of the SCI event router: synchronize sources, route them to GPEs,
// detect events, hold status and drive the interrupt request.
// Assumes NUM_GPE does not exceed the 32-bit register width.
module sci_gpe_router import sgr_pkg::*; #(
    parameter int NUM_SRC = 58,
    parameter int NUM_GPE = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_wr,
    input  logic               bus_size,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               sci_out
);
    localparam int GPE_W = $clog2(NUM_GPE);

    logic [NUM_SRC-1:0]       src_sync;
    logic [NUM_SRC*GPE_W-1:0] map_flat;
    logic [NUM_GPE-1:0]       pol_q;
    logic [NUM_GPE-1:0]       trig_q;
    logic [NUM_GPE-1:0]       ena_q;
    logic [NUM_GPE-1:0]       clr_mask;
    logic [NUM_GPE-1:0]       status_q;
    logic [NUM_GPE-1:0]       set_vec;
    logic [NUM_GPE-1:0]       gpe_raw;

    sgr_sync #(.W(NUM_SRC)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d (src_in),
        .q (src_sync)
    );

    sgr_regs #(.NUM_SRC(NUM_SRC), .NUM_GPE(NUM_GPE), .GPE_W(GPE_W)) u_regs (
        .clk (clk),
        .rst_n (rst_n),
        .bus_wr (bus_wr),
        .bus_size (bus_size),
        .bus_addr (bus_addr),
        .bus_wdata (bus_wdata),
        .status_q (status_q),
        .map_flat (map_flat),
        .pol_q (pol_q),
        .trig_q (trig_q),
        .ena_q (ena_q),
        .clr_mask (clr_mask),
        .bus_rdata (bus_rdata)
    );

    sgr_route #(.NUM_SRC(NUM_SRC), .NUM_GPE(NUM_GPE), .GPE_W(GPE_W)) u_route (
        .src_sync (src_sync),
        .map_flat (map_flat),
        .gpe_raw (gpe_raw)
    );

    sgr_detect #(.NUM_GPE(NUM_GPE)) u_detect (
        .clk (clk),
        .rst_n (rst_n),
        .gpe_raw (gpe_raw),
        .pol_q (pol_q),
        .trig_q (trig_q),
        .clr_mask (clr_mask),
        .set_vec (set_vec),
        .status_q (status_q)
    );

    // Interrupt request from enabled pending events.
    assign sci_out = |(status_q & ena_q);
endmodule

// File: rtl/sgr_chk.sv
`timescale 1ns/1ps
// Temporal checks across the register file and the detector of the
// SCI router. Bound to every instance of the top module.
module sgr_chk import sgr_pkg::*; #(
    parameter int NUM_GPE = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_size,
    input logic [7:0]         bus_addr,
    input logic [NUM_GPE-1:0] pol_q,
    input logic [NUM_GPE-1:0] clr_mask,
    input logic [NUM_GPE-1:0] set_vec,
    input logic [NUM_GPE-1:0] status_q
);
    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & ~set_vec)) |=> ((status_q & $past(clr_mask & ~set_vec)) == '0));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_q & ~clr_mask)) |=>
        ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

    // R10
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0) |=> ((status_q & ~$past(status_q)) == '0));

    // R11
    byte_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_size == ACC_BYTE && bus_addr == POL_OFS) |=> $stable(pol_q));
endmodule

bind sci_gpe_router sgr_chk #(.NUM_GPE(NUM_GPE)) u_sgr_chk (
    .clk (clk),
    .rst_n (rst_n),
    .bus_wr (bus_wr),
    .bus_size (bus_size),
    .bus_addr (bus_addr),
    .pol_q (pol_q),
    .clr_mask (clr_mask),
    .set_vec (set_vec),
    .status_q (status_q)
);

// File: tb/sci_gpe_router_bench.sv
`timescale 1ns/1ps
module sci_gpe_router_bench;
    localparam int NS = 58;
    localparam int NG = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          bus_wr = 1'b0;
    logic          bus_size = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          sci;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    sci_gpe_router #(.NUM_SRC(NS), .NUM_GPE(NG)) u_sci_gpe_router (
        .clk (clk), .rst_n (rst_n), .src_in (src),
        .bus_wr (bus_wr), .bus_size (bus_size), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .sci_out (sci)
    );

    always #2.5 clk = ~clk;

    // Reference model, built from the requirements
    logic [4:0]    m_map [NS];
    logic [31:0]   m_pol, m_trig, m_en, m_stat, m_prev;
    logic [NS-1:0] m_s1, m_s2;
    logic [31:0]   t_raw, t_act, t_set, t_clr;

    function automatic logic [31:0] f_raw(input logic [NS-1:0] s2);
        logic [31:0] r = '0;
        for (int s = 0; s < NS; s++) if (s2[s]) r[m_map[s]] = 1'b1;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) m_map[s] <= '0;
            m_pol <= '0; m_trig <= '0; m_en <= '0; m_stat <= '0;
            m_prev <= '1; m_s1 <= '0; m_s2 <= '0;
        end else begin
            t_raw = f_raw(m_s2);
            t_act = ~(t_raw ^ m_pol);
            t_set = (m_trig & t_act) | (~m_trig & t_act & ~m_prev);
            t_clr = (bus_wr && bus_size && bus_addr == 8'h10) ? bus_wdata : '0;
            m_stat <= (m_stat & ~t_clr) | t_set;
            m_prev <= t_act;
            m_s2 <= m_s1;
            m_s1 <= src;
            if (bus_wr && bus_size) begin
                if (bus_addr == 8'h08) m_pol  <= bus_wdata;
                if (bus_addr == 8'h0C) m_trig <= bus_wdata;
                if (bus_addr == 8'h14) m_en   <= bus_wdata;
            end
            if (bus_wr && !bus_size && bus_addr >= 8'h40 && bus_addr < 8'h40 + NS)
                m_map[bus_addr - 8'h40] <= bus_wdata[4:0];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sz, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_src(input int idx, input logic v);
        @(negedge clk);
        src[idx] = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; src = '0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [NS-1:0] mask;
        void'($urandom(32'd20417));

        do_reset();
        // R1 reset state
        rd(8'h08, v); chk("R1 polarity", v, 0);
        rd(8'h0C, v); chk("R1 trigger", v, 0);
        rd(8'h14, v); chk("R1 enable", v, 0);
        rd(8'h40, v); chk("R1 map0", v, 0);
        rd(8'h79, v); chk("R1 map57", v, 0);
        tick(3);
        rd(8'h10, v); chk("R1 status", v, 0);
        chk("R1 sci", {31'b0, sci}, 0);

        // R2 map byte writes
        wr(1'b0, 8'h45, 32'hFF); rd(8'h45, v); chk("R2 map5 low bits", v, 32'h1F);
        wr(1'b0, 8'h79, 32'h3);  rd(8'h79, v); chk("R2 map57", v, 32'h3);
        // R11 wrong-size accesses
        wr(1'b0, 8'h08, 32'hFF); rd(8'h08, v); chk("R11 byte to polarity", v, 0);
        wr(1'b1, 8'h45, 32'h7);  rd(8'h45, v); chk("R11 word to map", v, 32'h1F);
        // R3 word registers
        wr(1'b1, 8'h08, 32'hA5C3_0F96); rd(8'h08, v); chk("R3 polarity", v, 32'hA5C3_0F96);
        wr(1'b1, 8'h14, 32'h1234_5678); rd(8'h14, v); chk("R3 enable", v, 32'h1234_5678);
        wr(1'b1, 8'h0C, 32'h0F0F_0000); rd(8'h0C, v); chk("R3 trigger", v, 32'h0F0F_0000);
        rd(8'h08, v); chk("R3 polarity kept", v, 32'hA5C3_0F96);
        rd(8'h14, v); chk("R3 enable kept", v, 32'h1234_5678);

        do_reset();
        wr(1'b0, 8'h4A, 7); wr(1'b0, 8'h54, 7); wr(1'b0, 8'h5E, 3); wr(1'b0, 8'h68, 12);
        wr(1'b1, 8'h08, 32'h1080);
        wr(1'b1, 8'h0C, 32'h1000);
        wr(1'b1, 8'h14, 32'h80);
        tick(2);
        rd(8'h10, v); chk("R10 no event after setup", v, 0);

        // R10 latency, R5 edge, R9 interrupt
        set_src(10, 1'b1);
        tick(1); rd(8'h10, v); chk("R10 one edge", v, 0);
        tick(1); rd(8'h10, v); chk("R10 two edges", v, 0);
        tick(1); rd(8'h10, v); chk("R10 three edges", v, 32'h80);
        chk("R9 sci enabled", {31'b0, sci}, 1);
        set_src(10, 1'b0);
        tick(4); rd(8'h10, v); chk("R5 sticky", v, 32'h80);
        // R8 clear
        wr(1'b1, 8'h10, 32'h80); rd(8'h10, v); chk("R8 clear", v, 0);
        chk("R9 sci low", {31'b0, sci}, 0);

        // R4 OR of sources
        set_src(20, 1'b1);
        tick(3); rd(8'h10, v); chk("R4 second source", v, 32'h80);
        wr(1'b1, 8'h10, 32'h80);
        set_src(10, 1'b1);
        tick(4); rd(8'h10, v); chk("R4 no edge while OR high", v, 0);
        set_src(20, 1'b0); set_src(10, 1'b0);
        tick(4); rd(8'h10, v); chk("R4 falling no event", v, 0);

        // R6 active low
        set_src(30, 1'b1);
        tick(4); rd(8'h10, v); chk("R6 rising ignored", v, 0);
        set_src(30, 1'b0);
        tick(2); rd(8'h10, v); chk("R6 before latency", v, 0);
        tick(1); rd(8'h10, v); chk("R6 falling event", v, 32'h08);
        chk("R9 disabled bit", {31'b0, sci}, 0);
        wr(1'b1, 8'h14, 32'h88);
        chk("R9 after enable", {31'b0, sci}, 1);
        wr(1'b1, 8'h10, 32'h80); rd(8'h10, v); chk("R8 untouched bit", v, 32'h08);
        wr(1'b1, 8'h10, 32'h08); rd(8'h10, v); chk("R8 cleared bit", v, 0);

        // R7 level mode
        set_src(40, 1'b1);
        tick(3); rd(8'h10, v); chk("R7 level set", v, 32'h1000);
        wr(1'b1, 8'h10, 32'h1000); rd(8'h10, v); chk("R7 set wins", v, 32'h1000);
        tick(2); rd(8'h10, v); chk("R7 still active", v, 32'h1000);
        set_src(40, 1'b0);
        tick(3);
        wr(1'b1, 8'h10, 32'h1000); rd(8'h10, v); chk("R7 cleared after release", v, 0);

        // Random phase against the model
        do_reset();
        for (int s = 0; s < NS; s++) wr(1'b0, 8'h40 + 8'(s), $urandom);
        wr(1'b1, 8'h08, $urandom);
        wr(1'b1, 8'h0C, $urandom & $urandom);
        wr(1'b1, 8'h14, $urandom);
        wr(1'b1, 8'h10, 32'hFFFF_FFFF);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            rd(8'h10, v);
            chk("R4 R5 R6 R7 random status", v, m_stat);
            chk("R9 random sci", {31'b0, sci}, {31'b0, |(m_stat & m_en)});
            mask = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            src = src ^ mask;
            case ($urandom % 16)
                0: begin bus_wr = 1'b1; bus_size = 1'b1; bus_addr = 8'h10; bus_wdata = $urandom; end
                1: begin bus_wr = 1'b1; bus_size = 1'b0; bus_addr = 8'h40 + 8'($urandom % NS); bus_wdata = $urandom; end
                2: begin bus_wr = 1'b1; bus_size = 1'b1; bus_addr = 8'h08; bus_wdata = $urandom; end
                3: begin bus_wr = 1'b1; bus_size = 1'b1; bus_addr = 8'h0C; bus_wdata = $urandom & $urandom; end
                default: bus_wr = 1'b0;
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule